// File: doc/BRIEF.md
# Nonvolatile Store Access Controller

This block is the register front end that a CPU uses to reach an on-chip nonvolatile store. Software picks one of three targets: the data EEPROM, the program flash or the configuration space. It loads a byte address and a byte of data, and then starts a one-cycle read or a timed program operation. A program operation is either a write or an erase, chosen by a mode bit. A program operation needs two things to start. The write-enable bit must already be set. The two bus writes just before the start command must be the key bytes 0x55 and then 0xAA, sent to an unlock offset that stores nothing.

Hardware clears the start bits when their operation completes. When a program operation completes, a sticky completion flag is set. A system reset that lands during a program operation sets a sticky error flag. That reset also clears the address, data and control registers. Only a power-on reset or a software write of 0 clears the error flag.

The register side is a plain write strobe with a combinational read mux. The memory side is a plain strobe port and has no back-pressure: the store must accept a read in the cycle `mem_rd_en` is high, and must hold a program operation for exactly as long as `mem_prog` is high. No interface of this block carries a valid/ready handshake, so neither side can stall the other.

Top module: `nvm_ctrl`

## Requirements
- R1: `mem_target` is 2'b10 (configuration) when control bit 6 is 1. Otherwise it is 2'b01 (program flash) when control bit 7 is 1, and 2'b00 (data EEPROM) when bit 7 is 0.
- R2: After power-on reset, the control register (offset 0), the address register (offset 2) and the data register (offset 3) all read 0x00.
- R3: Writing 1 to control bit 1 (program start) is accepted only when both of these hold: control bit 2 (write enable) was already 1 before this write, and the two bus writes just before it put 0x55 and then 0xAA into offset 1. Any other bus write between those writes cancels the unlock. A rejected start leaves bit 1 at 0 and `mem_prog` low.
- R4: Offset 1 stores nothing and always reads 0x00.
- R5: An accepted program operation holds `mem_prog` high for exactly PROG_CYCLES cycles. `mem_erase` is high throughout when control bit 4 (erase mode) was 1, and low otherwise. Clearing write enable during the operation neither shortens nor aborts it.
- R6: Control bit 1 reads 1 while programming, and hardware clears it at the end. At that same edge, control bit 5 (completion flag) is set. The flag stays set until software writes 0 to it, and a completion in the same cycle as that write wins.
- R7: Writing 1 to control bit 0 (read start) while idle, with bit 7 of the same written byte at 0, starts a read. `mem_rd_en` is high for one cycle, the data register is loaded with `mem_rdata`, and bit 0 then returns to 0. If bit 7 of the written byte is 1, bit 0 stays 0 and no read occurs.
- R8: A low `rst_n` during a program operation sets control bit 3 (error flag). A later `rst_n` does not clear that flag. Writing 0 to bit 3 clears it, and writing 1 to it has no effect. `rst_n` clears the address register, the data register and every other control bit.
- R9: While a program operation runs, writes to the address register, the data register and control bits 4, 6 and 7 are ignored. `mem_addr` and `mem_wdata` present the address and data registers.
- R10: Read-start writes are ignored while a program operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low; clears everything |
| rst_n | input | 1 | Synchronous system reset, active low; keeps the error flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset: 0 control, 1 unlock, 2 address, 3 data |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| mem_target | output | 2 | Selected store: 00 EEPROM, 01 program, 10 configuration |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_prog | output | 1 | Program operation in progress |
| mem_erase | output | 1 | Current program operation is an erase |
| mem_addr | output | ADDR_W | Byte address to the store |
| mem_wdata | output | DATA_W | Data to the store |
| mem_rdata | input | DATA_W | Read data from the store, sampled while `mem_rd_en` is high |

## Verification
The sharpest collision is between the completion of a program operation and a software write that clears the completion flag. The bench sets the flag with an erase, then starts a second operation. It times a control write with bit 5 at 0 so that this write reaches the very edge where the timer expires. It then expects bit 5 to read back as 1. A second collision is between a system reset and a running operation: the bench pulls `rst_n` low in the middle of a program operation. It judges the result by reading the error bit and the cleared address and data registers through the bus.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int BUS_W = 8;

  // register offsets
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_KEY  = 2'd1;
  localparam logic [1:0] OFS_ADDR = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  // control bit positions
  localparam int B_RDGO  = 0;
  localparam int B_WRGO  = 1;
  localparam int B_WREN  = 2;
  localparam int B_ERR   = 3;
  localparam int B_ERASE = 4;
  localparam int B_DONE  = 5;
  localparam int B_CFG   = 6;
  localparam int B_PROG  = 7;

  localparam logic [BUS_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BUS_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    TGT_EEPROM = 2'b00,
    TGT_FLASH  = 2'b01,
    TGT_CONFIG = 2'b10
  } target_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             wr,
  input  logic             key_hit,
  input  logic [BUS_W-1:0] wdata,
  output logic             armed
);
  unlock_e state_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q <= UL_IDLE;
    end else if (wr) begin
      if (key_hit && wdata == KEY_FIRST)
        state_q <= UL_HALF;
      else if (state_q == UL_HALF && key_hit && wdata == KEY_SECOND)
        state_q <= UL_ARMED;
      else
        state_q <= UL_IDLE;
    end
  end

  assign armed = (state_q == UL_ARMED);

  // R3
  arm_order_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(armed) |-> $past(state_q == UL_HALF && wr && key_hit));
endmodule

// File: rtl/nvm_timer.sv
module nvm_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic fin
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST) busy <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fin = busy && (cnt_q == LAST);

  // R5
  prog_end_chk: assert property (@(posedge clk) disable iff (clr)
    (busy && cnt_q == LAST) |=> !busy);
  // R5
  prog_start_chk: assert property (@(posedge clk) disable iff (clr)
    (start && !busy) |=> (busy && cnt_q == '0));
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [1:0]        mem_target,
  output logic              mem_rd_en,
  output logic              mem_prog,
  output logic              mem_erase,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic clr;
  assign clr = !rst_n || !por_n;

  logic rd_go_q, wr_en_q, err_q, erase_q, done_q, cfg_q, prog_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic busy, fin, armed;
  logic ctrl_wr, start, rd_acc;
  target_e tgt;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign start   = ctrl_wr && bus_wdata[B_WRGO] && wr_en_q && armed
                   && !busy && !rd_go_q;
  assign rd_acc  = ctrl_wr && bus_wdata[B_RDGO] && !bus_wdata[B_PROG]
                   && !busy && !rd_go_q && !start;

  nvm_unlock u_unlock (
    .clk     (clk),
    .clr     (clr),
    .wr      (bus_wr),
    .key_hit (bus_addr == OFS_KEY),
    .wdata   (bus_wdata),
    .armed   (armed)
  );

  nvm_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .clr   (clr),
    .start (start),
    .busy  (busy),
    .fin   (fin)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_go_q <= 1'b0;
      wr_en_q <= 1'b0;
      erase_q <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= 1'b0;
      prog_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        wr_en_q <= bus_wdata[B_WREN];
        if (!busy) begin
          erase_q <= bus_wdata[B_ERASE];
          cfg_q   <= bus_wdata[B_CFG];
          prog_q  <= bus_wdata[B_PROG];
        end
        if (!bus_wdata[B_DONE]) done_q <= 1'b0;
      end
      if (bus_wr && bus_addr == OFS_ADDR && !busy) addr_q <= ADDR_W'(bus_wdata);
      if (bus_wr && bus_addr == OFS_DATA && !busy) data_q <= DATA_W'(bus_wdata);
      if (rd_go_q) begin
        rd_go_q <= 1'b0;
        data_q  <= mem_rdata;
      end
      if (rd_acc) rd_go_q <= 1'b1;
      if (fin)    done_q  <= 1'b1;
    end
  end

  // error flag: only power-on reset or software clears it
  always_ff @(posedge clk) begin
    if (!por_n)                              err_q <= 1'b0;
    else if (!rst_n)                         err_q <= err_q | busy;
    else if (ctrl_wr && !bus_wdata[B_ERR])   err_q <= 1'b0;
  end

  always_comb begin
    if (cfg_q)       tgt = TGT_CONFIG;
    else if (prog_q) tgt = TGT_FLASH;
    else             tgt = TGT_EEPROM;
  end

  assign mem_target = tgt;
  assign mem_rd_en  = rd_go_q;
  assign mem_prog   = busy;
  assign mem_erase  = busy && erase_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {prog_q, cfg_q, done_q, erase_q, err_q, wr_en_q, busy, rd_go_q};
      OFS_ADDR: bus_rdata = BUS_W'(addr_q);
      OFS_DATA: bus_rdata = BUS_W'(data_q);
      default:  bus_rdata = '0;
    endcase
  end

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(busy) |-> $past(wr_en_q && armed && ctrl_wr));
  // R4
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (clr)
    (bus_addr == OFS_KEY) |-> (bus_rdata == '0));
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(done_q) |-> $past(ctrl_wr && !bus_wdata[B_DONE] && !fin));
  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (clr)
    mem_rd_en |=> !mem_rd_en);
  // R8
  err_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && err_q) |=> err_q);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));
  // R10
  rd_block_chk: assert property (@(posedge clk) disable iff (clr)
    busy |-> !mem_rd_en);
endmodule

// File: tb/test_nvm_ctrl.sv
module test_nvm_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] mem_target;
  logic       mem_rd_en, mem_prog, mem_erase;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;

  int n_cmp = 0, n_bad = 0, prog_cnt = 0;
  bit finished = 0;

  always #5ns clk = ~clk;
  assign mem_rdata = ~mem_addr;

  nvm_ctrl i_nvm_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_target(mem_target), .mem_rd_en(mem_rd_en), .mem_prog(mem_prog),
    .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(negedge clk) if (mem_prog) prog_cnt++;

  typedef struct packed {
    logic       is_rd;
    logic [1:0] a;
    logic [7:0] d;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 8'h00, 4'd2},  // R2 control after reset
    '{1'b1, 2'd2, 8'h00, 4'd2},  // R2 address
    '{1'b1, 2'd3, 8'h00, 4'd2},  // R2 data
    '{1'b0, 2'd2, 8'h3C, 4'd9},
    '{1'b1, 2'd2, 8'h3C, 4'd9},  // R9 address register
    '{1'b0, 2'd3, 8'hA5, 4'd9},
    '{1'b1, 2'd3, 8'hA5, 4'd9},  // R9 data register
    '{1'b0, 2'd1, 8'h55, 4'd4},
    '{1'b1, 2'd1, 8'h00, 4'd4},  // R4 key offset reads zero
    '{1'b0, 2'd0, 8'h02, 4'd3},
    '{1'b1, 2'd0, 8'h00, 4'd3},  // R3 start without enable
    '{1'b0, 2'd1, 8'h55, 4'd3},
    '{1'b0, 2'd1, 8'hAA, 4'd3},
    '{1'b0, 2'd0, 8'h02, 4'd3},
    '{1'b1, 2'd0, 8'h00, 4'd3},  // R3 unlocked but enable clear
    '{1'b0, 2'd0, 8'h04, 4'd3},
    '{1'b1, 2'd0, 8'h04, 4'd3},
    '{1'b0, 2'd0, 8'h06, 4'd3},
    '{1'b1, 2'd0, 8'h04, 4'd3},  // R3 enabled but no unlock
    '{1'b0, 2'd0, 8'hD4, 4'd1},
    '{1'b1, 2'd0, 8'hD4, 4'd1},  // R1 select bits stored
    '{1'b0, 2'd0, 8'h00, 4'd2},
    '{1'b1, 2'd0, 8'h00, 4'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rchk(input logic [1:0] a, input logic [7:0] exp, input string req);
    bus_addr = a;
    #1ns;
    chk(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic unlock_start(input logic [7:0] ctrl);
    bwr(2'd1, 8'h55);
    bwr(2'd1, 8'hAA);
    prog_cnt = 0;
    bwr(2'd0, ctrl);
    #1ns;
  endtask

  task automatic wait_idle;
    while (mem_prog) @(negedge clk);
    #1ns;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) rchk(VECS[i].a, VECS[i].d, $sformatf("R%0d vec%0d", VECS[i].req, i));
      else               bwr(VECS[i].a, VECS[i].d);
    end

    // R1 target selection
    bwr(2'd0, 8'h80); #1ns; chk("R1 flash", 32'(mem_target), 32'h1);
    bwr(2'd0, 8'hC0); #1ns; chk("R1 cfg+flash", 32'(mem_target), 32'h2);
    bwr(2'd0, 8'h40); #1ns; chk("R1 cfg", 32'(mem_target), 32'h2);
    bwr(2'd0, 8'h00); #1ns; chk("R1 eeprom", 32'(mem_target), 32'h0);

    // R7 read and blocked read
    bwr(2'd2, 8'h12);
    bwr(2'd0, 8'h01); #1ns;
    chk("R7 rd strobe", 32'(mem_rd_en), 32'h1);
    rchk(2'd0, 8'h01, "R7 rd bit set");
    @(negedge clk);
    rchk(2'd3, 8'hED, "R7 data loaded");
    rchk(2'd0, 8'h00, "R7 rd bit cleared");
    chk("R7 strobe one cycle", 32'(mem_rd_en), 32'h0);
    bwr(2'd0, 8'h81); #1ns;
    chk("R7 blocked strobe", 32'(mem_rd_en), 32'h0);
    rchk(2'd0, 8'h80, "R7 blocked bit");
    bwr(2'd0, 8'h00);

    // R5 R9 R10 write operation, enable cleared midway
    bwr(2'd2, 8'h20);
    bwr(2'd3, 8'h77);
    bwr(2'd0, 8'h04);
    unlock_start(8'h06);
    chk("R5 prog high", 32'(mem_prog), 32'h1);
    chk("R5 no erase", 32'(mem_erase), 32'h0);
    chk("R9 mem_addr", 32'(mem_addr), 32'h20);
    chk("R9 mem_wdata", 32'(mem_wdata), 32'h77);
    bwr(2'd0, 8'h80);
    bwr(2'd2, 8'h99);
    bwr(2'd0, 8'h01); #1ns;
    chk("R10 read ignored", 32'(mem_rd_en), 32'h0);
    chk("R9 addr held", 32'(mem_addr), 32'h20);
    chk("R9 target held", 32'(mem_target), 32'h0);
    wait_idle();
    chk("R5 length", 32'(prog_cnt), 32'd16);
    rchk(2'd0, 8'h20, "R6 done set, start cleared");
    rchk(2'd2, 8'h20, "R9 addr write dropped");
    bwr(2'd0, 8'h00);
    rchk(2'd0, 8'h00, "R6 done cleared by 0");

    // R5 erase
    bwr(2'd0, 8'h14);
    unlock_start(8'h16);
    chk("R5 erase high", 32'(mem_erase), 32'h1);
    rchk(2'd0, 8'h16, "R6 start bit reads 1");
    wait_idle();
    chk("R5 erase length", 32'(prog_cnt), 32'd16);
    rchk(2'd0, 8'h34, "R6 done after erase");

    // R6 collision: clear write lands on the completion edge
    unlock_start(8'h16);
    repeat (14) @(negedge clk);
    bwr(2'd0, 8'h14); #1ns;
    rchk(2'd0, 8'h34, "R6 completion wins");
    chk("R6 collision length", 32'(prog_cnt), 32'd16);
    bwr(2'd0, 8'h14);
    rchk(2'd0, 8'h14, "R6 clear afterwards");

    // R3 broken unlock sequences
    bwr(2'd0, 8'h04);
    bwr(2'd1, 8'h55); bwr(2'd2, 8'h11); bwr(2'd1, 8'hAA);
    bwr(2'd0, 8'h06); #1ns;
    chk("R3 interrupted unlock", 32'(mem_prog), 32'h0);
    bwr(2'd1, 8'h55); bwr(2'd1, 8'hAA); bwr(2'd3, 8'h00);
    bwr(2'd0, 8'h06); #1ns;
    chk("R3 stale unlock", 32'(mem_prog), 32'h0);
    bwr(2'd1, 8'hAA); bwr(2'd1, 8'h55);
    bwr(2'd0, 8'h06); #1ns;
    chk("R3 wrong order", 32'(mem_prog), 32'h0);

    // R8 reset during programming
    bwr(2'd2, 8'h40);
    bwr(2'd3, 8'h41);
    unlock_start(8'h06);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1ns;
    chk("R8 prog stopped", 32'(mem_prog), 32'h0);
    rchk(2'd0, 8'h08, "R8 error set");
    rchk(2'd2, 8'h00, "R8 addr cleared");
    rchk(2'd3, 8'h00, "R8 data cleared");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rchk(2'd0, 8'h08, "R8 error survives reset");
    bwr(2'd0, 8'h08);
    rchk(2'd0, 8'h08, "R8 write 1 keeps");
    bwr(2'd0, 8'h00);
    rchk(2'd0, 8'h00, "R8 write 0 clears");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rchk(2'd0, 8'h00, "R8 idle reset no error");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule